// File: doc/BRIEF.md
# Receive descriptor ring engine

This block is the device-side controller for one receive ring of buffer descriptors kept in host memory. Software programs three values over a small write-only register port: a configuration word, the ring base address (256-byte aligned, given as address bits 35:8) and the host index. The host index points one slot past the last descriptor that software has prepared. The engine walks the ring in order. For each slot it fetches the descriptor, which holds bits 35:8 of a buffer address. It then writes words from the incoming frame stream into that buffer until the buffer is full or a programmable quiet period expires.

Each time a buffer is closed, the engine emits a one-cycle status write that carries the index of the descriptor just filled. When host interrupts are selected, it raises an interrupt pulse in the same cycle. When the fill index equals the host index, the engine treats the ring as having no room and waits. A channel mode field selects one of three behaviours: run, stop at the end of the current frame, or stop at once. An idle output reports when the channel has come to rest.

Memory traffic is abstracted into two request/acknowledge ports: one for descriptor reads and one for buffer word writes. The size of a 4K unit in words (`UNIT_WORDS`) and the number of clock cycles in one 32 µs timeout unit (`TICK_CYCLES`) are parameters.

Top module: `rxr_ring_engine`

## Requirements
- R1: After reset the engine is idle: `chan_idle`=1, `in_ready`=0, `desc_req`=0, `stat_we`=0, and the fill index is 0.
- R2: Descriptor fetches happen one per buffer, in ring order, at byte address base×256 + 4×index. The index wraps modulo 2^k, where k is config bits [23:20], clamped to the range 5..12.
- R3: Word n of a buffer is written at byte address descriptor[27:0]×256 + 4×n, with `wr_data` equal to the accepted input word.
- R4: A buffer closes after (s+1)×`UNIT_WORDS` accepted words, where s is config bits [17:16]. No write is requested beyond that count.
- R5: Closing a buffer produces a status write lasting exactly one cycle. Bits [11:0] of the status word hold the index of the filled descriptor, and bits [31:12] are 0.
- R6: `irq` pulses together with the status write if and only if config bits [13:12] equal 01. `irq` is never high without `stat_we`.
- R7: While the fill index equals the host index, no descriptor is fetched and no input word is accepted.
- R8: With t = config bits [11:4] nonzero, the engine counts quiet cycles while a buffer is partly filled and the channel is running. If t×`TICK_CYCLES` cycles pass with no accepted word, the buffer closes, and its status write appears t×`TICK_CYCLES`+1 clock edges after the edge that accepted the last word.
- R9: Mode 01 (config bits [31:30]) lets the frame in progress finish, up to the word flagged `in_last`. After that, no word is accepted and `chan_idle` is 1. The quiet-period timer does not run in this mode.
- R10: Mode 00 or 11 stops word acceptance from the cycle after the write. `chan_idle` is 1 whenever no descriptor fetch or status write is in progress. The open buffer is kept and is not closed.
- R11: The host index is written with register select 2 (select 0 is the configuration word, select 1 is the base). The index wraps at ring end and is only ever advanced by multiples of eight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 config, 1 ring base, 2 host index |
| reg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Input stream word valid |
| in_data | input | DATA_W | Input stream word |
| in_last | input | 1 | Marks the final word of a frame |
| in_ready | output | 1 | Input word is taken at this edge when valid |
| desc_req | output | 1 | Descriptor read request |
| desc_addr | output | 36 | Descriptor byte address |
| desc_ack | input | 1 | Descriptor read complete, `desc_data` valid |
| desc_data | input | 28 | Buffer address bits 35:8 |
| wr_req | output | 1 | Buffer word write request |
| wr_addr | output | 36 | Buffer word byte address |
| wr_data | output | DATA_W | Buffer word data |
| wr_ack | input | 1 | Buffer write accepted at this edge |
| stat_we | output | 1 | Status write strobe |
| stat_word | output | 32 | Status word, bits [11:0] latest filled index |
| irq | output | 1 | Host interrupt pulse |
| chan_idle | output | 1 | Channel at rest |

## Verification
The assertions assume three things about the host. It writes the host index only in steps of eight and never moves it onto or past the fill index. It changes the buffer size only when no buffer is open. The memory side acknowledges a descriptor only while one is requested. The stimulus keeps to all three rules. Index writes are always multiples of eight ahead, and the last one wraps to 0 exactly where the ring runs dry. The size and mode fields are rewritten only between buffers, or while a buffer is paused. Descriptor acknowledges come from a responder that answers each request once, one cycle later.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int IDX_W  = 12;
  localparam int BASE_W = 28;
  localparam int ADDR_W = 36;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_OPEN, ST_CLOSE} rxr_state_e;

  // Ring index mask for an exponent field, clamped to 5..12.
  function automatic logic [IDX_W-1:0] ring_mask(input logic [3:0] k);
    int kk;
    kk = (k < 4'd5) ? 5 : ((k > 4'd12) ? 12 : int'(k));
    return IDX_W'((1 << kk) - 1);
  endfunction

  function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] idx,
                                                 input logic [IDX_W-1:0] mask);
    return (idx + IDX_W'(1)) & mask;
  endfunction

  function automatic int buf_words(input logic [1:0] code, input int unit);
    return (int'(code) + 1) * unit;
  endfunction

  function automatic int quiet_limit(input logic [7:0] t, input int tick);
    return int'(t) * tick;
  endfunction

  function automatic logic [ADDR_W-1:0] slot_addr(input logic [BASE_W-1:0] base,
                                                  input logic [IDX_W-1:0] idx);
    return {base, 8'h00} + ADDR_W'({idx, 2'b00});
  endfunction
endpackage

// File: rtl/rxr_host_regs.sv
module rxr_host_regs
  import rxr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [31:0]       wdata,
  output logic [1:0]        mode_o,
  output logic [3:0]        kexp_o,
  output logic [1:0]        size_o,
  output logic [1:0]        dest_o,
  output logic [7:0]        tmo_o,
  output logic [BASE_W-1:0] base_o,
  output logic [IDX_W-1:0]  hidx_o
);
  wire unused_wbits = ^{wdata[29:24], wdata[19:18], wdata[15:14], wdata[3:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_o <= '0; kexp_o <= 4'd5; size_o <= '0; dest_o <= '0; tmo_o <= '0;
      base_o <= '0; hidx_o <= '0;
    end else if (we) begin
      case (sel)
        2'd0: begin
          mode_o <= wdata[31:30];
          kexp_o <= wdata[23:20];
          size_o <= wdata[17:16];
          dest_o <= wdata[13:12];
          tmo_o  <= wdata[11:4];
        end
        2'd1: base_o <= wdata[BASE_W-1:0];
        2'd2: hidx_o <= wdata[IDX_W-1:0];
        default: ;
      endcase
    end
  end

  // R11
  hidx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == 2'd2) |-> (wdata[2:0] == 3'b000));
endmodule

// File: rtl/rxr_quiet_timer.sv
module rxr_quiet_timer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        active,
  input  logic        word_go,
  input  logic [31:0] limit,
  output logic        expire
);
  logic [31:0] quiet_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       quiet_q <= '0;
    else if (!active || word_go)      quiet_q <= '0;
    else if (quiet_q != limit)        quiet_q <= quiet_q + 32'd1;
  end

  assign expire = active && !word_go && (limit != 32'd0) && (quiet_q == limit);

  // R8
  quiet_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);
endmodule

// File: rtl/rxr_ring_engine.sv
module rxr_ring_engine
  import rxr_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int UNIT_WORDS  = 1024,
  parameter int TICK_CYCLES = 1600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              desc_req,
  output logic [35:0]       desc_addr,
  input  logic              desc_ack,
  input  logic [27:0]       desc_data,
  output logic              wr_req,
  output logic [35:0]       wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic              wr_ack,
  output logic              stat_we,
  output logic [31:0]       stat_word,
  output logic              irq,
  output logic              chan_idle
);
  localparam int MAX_WORDS = 4 * UNIT_WORDS;
  localparam int CNT_W     = $clog2(MAX_WORDS + 1);

  logic [1:0]        mode;
  logic [3:0]        kexp;
  logic [1:0]        size;
  logic [1:0]        dest;
  logic [7:0]        tmo;
  logic [BASE_W-1:0] base;
  logic [IDX_W-1:0]  hidx;

  rxr_host_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .mode_o(mode), .kexp_o(kexp), .size_o(size), .dest_o(dest), .tmo_o(tmo),
    .base_o(base), .hidx_o(hidx)
  );

  rxr_state_e        state;
  logic [IDX_W-1:0]  fill_idx;
  logic [CNT_W-1:0]  wcnt;
  logic [35:0]       buf_base;
  logic              in_frame;

  // Named internal events
  logic             mode_run, mode_eof, mode_off;
  logic             allow, is_open, word_go, full_evt, quiet_evt, close_evt;
  logic             room, fetch_start;
  logic [IDX_W-1:0] mask, hidx_m;
  logic [CNT_W-1:0] cap_w;
  logic [31:0]      quiet_lim;

  assign mode_run  = (mode == 2'b10);
  assign mode_eof  = (mode == 2'b01);
  assign mode_off  = !mode_run && !mode_eof;
  assign mask      = ring_mask(kexp);
  assign hidx_m    = hidx & mask;
  assign cap_w     = CNT_W'(buf_words(size, UNIT_WORDS));
  assign quiet_lim = 32'(quiet_limit(tmo, TICK_CYCLES));

  assign allow       = mode_run || (mode_eof && in_frame);
  assign is_open     = (state == ST_OPEN);
  assign room        = (fill_idx != hidx_m);
  assign fetch_start = (state == ST_IDLE) && allow && room;
  assign word_go     = wr_req && wr_ack;
  assign full_evt    = word_go && ((wcnt + CNT_W'(1)) == cap_w);
  assign close_evt   = full_evt || quiet_evt;

  rxr_quiet_timer u_quiet (
    .clk(clk), .rst_n(rst_n),
    .active(is_open && mode_run && (wcnt != '0)),
    .word_go(word_go), .limit(quiet_lim), .expire(quiet_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      fill_idx <= '0;
      wcnt     <= '0;
      buf_base <= '0;
      in_frame <= 1'b0;
    end else begin
      if (word_go) in_frame <= !in_last;
      case (state)
        ST_IDLE:  if (fetch_start) state <= ST_FETCH;
        ST_FETCH: if (desc_ack) begin
          buf_base <= {desc_data, 8'h00};
          wcnt     <= '0;
          state    <= ST_OPEN;
        end
        ST_OPEN: begin
          if (word_go)   wcnt  <= wcnt + CNT_W'(1);
          if (close_evt) state <= ST_CLOSE;
        end
        ST_CLOSE: begin
          fill_idx <= next_idx(fill_idx, mask);
          wcnt     <= '0;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign desc_req  = (state == ST_FETCH);
  assign desc_addr = slot_addr(base, fill_idx);
  assign in_ready  = is_open && allow && wr_ack;
  assign wr_req    = is_open && allow && in_valid;
  assign wr_addr   = buf_base + 36'({wcnt, 2'b00});
  assign wr_data   = in_data;
  assign stat_we   = (state == ST_CLOSE);
  assign stat_word = {20'h0, fill_idx};
  assign irq       = stat_we && (dest == 2'b01);
  assign chan_idle = (state != ST_FETCH) && (state != ST_CLOSE) &&
                     (mode_off || (mode_eof && !in_frame));

  // R5
  stat_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |=> !stat_we);
  // R6
  irq_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> stat_we);
  // R7
  fetch_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_req && !$past(desc_req)) |-> $past(fill_idx != hidx_m));
  // R4
  word_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (wcnt < cap_w));
  // R10
  off_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_off |-> !in_ready);
  // R9
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_idle |-> !in_ready);
endmodule

// File: tb/rxr_ring_engine_bench.sv
module rxr_ring_engine_bench;
  localparam int UW  = 4;
  localparam int TK  = 4;
  localparam int TMO = 3;
  localparam logic [27:0] BASE = 28'h0012345;
  localparam logic [31:0] RUN = 32'h8000_0000, PEOF = 32'h4000_0000;
  localparam logic [31:0] K5 = 32'h0050_0000, SZ1 = 32'h0001_0000;
  localparam logic [31:0] HOST = 32'h0000_1000, T3 = 32'h0000_0030;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0; logic [1:0] reg_sel = 0; logic [31:0] reg_wdata = 0;
  logic in_valid = 0, in_last = 0; logic [31:0] in_data = 0;
  logic in_ready, desc_req, wr_req, stat_we, irq, chan_idle;
  logic [35:0] desc_addr, wr_addr; logic [31:0] wr_data, stat_word;
  logic desc_ack = 0; logic [27:0] desc_data = 0; logic wr_ack = 1; logic stall = 0;

  rxr_ring_engine #(.DATA_W(32), .UNIT_WORDS(UW), .TICK_CYCLES(TK)) u_rxr_ring_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .desc_req(desc_req), .desc_addr(desc_addr), .desc_ack(desc_ack), .desc_data(desc_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
    .stat_we(stat_we), .stat_word(stat_word), .irq(irq), .chan_idle(chan_idle));

  always #10 clk = ~clk;

  int cyc = 0;
  int checks = 0, fails = 0;
  int exp_idx = 0, exp_cnt = 0, exp_cap = UW, stat_cnt = 0, last_acc = 0;
  logic [35:0] exp_buf = '0;
  bit exp_irq = 0, exp_to = 0;

  function automatic logic [27:0] fdesc(input logic [35:0] a);
    return 28'h0500000 | {16'h0, a[13:2]};
  endfunction

  always @(posedge clk) begin
    cyc      <= cyc + 1;
    desc_ack <= desc_req && !desc_ack;
    desc_data <= fdesc(desc_addr);
    wr_ack   <= stall ? ~wr_ack : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Reference model, evaluated every cycle away from the edge
  always begin
    @(negedge clk); #5;
    if (rst_n) begin
      if (desc_req && desc_ack) begin
        chk(desc_addr == ({BASE, 8'h00} + 36'(exp_idx * 4)), "R2", "desc_addr",
            desc_addr, {BASE, 8'h00} + 36'(exp_idx * 4));
        exp_buf = {fdesc(desc_addr), 8'h00};
      end
      if (wr_req && wr_ack) begin
        chk(wr_addr == exp_buf + 36'(exp_cnt * 4), "R3", "wr_addr",
            wr_addr, exp_buf + 36'(exp_cnt * 4));
        chk(wr_data == in_data, "R3", "wr_data", wr_data, in_data);
        exp_cnt++;
        last_acc = cyc;
      end
      if (stat_we) begin
        chk(stat_word == 32'(exp_idx), "R5", "stat_word", stat_word, exp_idx);
        chk(irq == exp_irq, "R6", "irq", irq, exp_irq);
        if (exp_to) begin
          chk(cyc - last_acc == TMO * TK + 2, "R8", "quiet close delay",
              cyc - last_acc, TMO * TK + 2);
          chk(exp_cnt == 3, "R8", "partial count", exp_cnt, 3);
        end else
          chk(exp_cnt == exp_cap, "R4", "words per buffer", exp_cnt, exp_cap);
        exp_idx = (exp_idx + 1) % 32;
        exp_cnt = 0;
        stat_cnt++;
      end else if (irq)
        chk(0, "R6", "irq without status", 1, 0);
    end
  end

  task automatic wr_reg(input logic [1:0] s, input logic [31:0] v);
    reg_sel = s; reg_wdata = v; reg_we = 1;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic push(input logic [31:0] d, input bit l);
    in_valid = 1; in_data = d; in_last = l;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0; in_last = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(chan_idle == 1, "R1", "idle after reset", chan_idle, 1);
    chk(in_ready == 0, "R1", "in_ready after reset", in_ready, 0);
    chk(desc_req == 0, "R1", "desc_req after reset", desc_req, 0);
    chk(stat_we == 0, "R1", "stat_we after reset", stat_we, 0);

    // Fill eight 4-word buffers, host interrupts on
    exp_cap = UW; exp_irq = 1;
    wr_reg(2'd1, 32'(BASE));
    wr_reg(2'd2, 32'd8);
    wr_reg(2'd0, RUN | K5 | HOST);
    for (int i = 0; i < 32; i++) push(32'hA000 + 32'(i), (i % 4) == 3);
    in_valid = 1;
    repeat (6) begin
      @(negedge clk);
      chk(in_ready == 0, "R7", "no room in_ready", in_ready, 0);
      chk(desc_req == 0, "R7", "no room desc_req", desc_req, 0);
    end
    in_valid = 0;
    chk(stat_cnt == 8, "R7", "buffers before stop", stat_cnt, 8);

    // Host index wraps to 0; write-side stalls
    stall = 1;
    wr_reg(2'd2, 32'd0);
    for (int i = 0; i < 96; i++) push(32'hB000 + 32'(i), (i % 4) == 3);
    repeat (5) @(negedge clk);
    chk(stat_cnt == 32, "R11", "buffers after wrap", stat_cnt, 32);
    chk(desc_req == 0, "R7", "stopped at wrap", desc_req, 0);
    stall = 0;

    // Quiet-period close, interrupts off, 8-word buffers
    exp_cap = 2 * UW; exp_irq = 0; exp_to = 1;
    wr_reg(2'd0, RUN | K5 | SZ1 | T3);
    wr_reg(2'd2, 32'd8);
    for (int i = 0; i < 3; i++) push(32'hC000 + 32'(i), 0);
    repeat (30) @(negedge clk);
    chk(stat_cnt == 33, "R8", "quiet close count", stat_cnt, 33);
    exp_to = 0;

    for (int i = 0; i < 8; i++) push(32'hD000 + 32'(i), i == 7);
    repeat (3) @(negedge clk);
    chk(stat_cnt == 34, "R4", "full close count", stat_cnt, 34);

    // Pause at end of frame
    push(32'hE000, 0);
    push(32'hE001, 0);
    wr_reg(2'd0, PEOF | K5 | SZ1 | T3);
    push(32'hE002, 0);
    push(32'hE003, 1);
    in_valid = 1;
    repeat (5) begin
      @(negedge clk);
      chk(in_ready == 0, "R9", "in_ready after frame", in_ready, 0);
      chk(chan_idle == 1, "R9", "idle after frame", chan_idle, 1);
    end
    in_valid = 0;
    repeat (30) @(negedge clk);
    chk(stat_cnt == 34, "R9", "no close while paused", stat_cnt, 34);

    // Resume, then stop at once
    wr_reg(2'd0, RUN | K5 | SZ1 | T3);
    for (int i = 0; i < 4; i++) push(32'hF000 + 32'(i), i == 3);
    push(32'hF100, 0);
    push(32'hF101, 0);
    wr_reg(2'd0, 32'd0);
    in_valid = 1;
    repeat (4) begin
      @(negedge clk);
      chk(in_ready == 0, "R10", "in_ready when off", in_ready, 0);
      chk(chan_idle == 1, "R10", "idle when off", chan_idle, 1);
    end
    in_valid = 0;
    repeat (30) @(negedge clk);
    chk(stat_cnt == 35, "R10", "open buffer kept", stat_cnt, 35);
    chk(exp_cnt == 2, "R10", "words in kept buffer", exp_cnt, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule